// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Pipelined Read

A behavioural, synthesizable model of a single-port synchronous static RAM of 18-bit words, split into two 9-bit byte lanes. Every control and data input is captured on the rising clock edge. A cycle either loads a fresh starting address through one of two address strobes, or continues a burst from that address. Continuation uses an internal 2-bit counter, which steps in linear or interleaved order. The upper address bits stay fixed for the whole burst, so a burst covers four words and then wraps.

Writes are enabled per lane behind a common lane gate, and a separate all-lanes control writes both lanes at once. Reads pass through an address stage and an output register, so the first word of a burst appears one clock after its access edge and each further word follows one clock later. Chip selection is sampled only when an address is loaded. A deselecting load stops output drive one clock later, which is the second edge counted from the load. The read-data pins carry a drive flag in place of a real three-state pad. An asynchronous output-enable input clears that flag at once.

The depth is a parameter, so a small array can be used in simulation. The style's valid/ready convention does not fit a memory that performs one access every clock, so all pins are plain.

Top module: `burst_sram`

## Requirements
- R1: An address is loaded when `strobe_ctl_n` is low, or when `strobe_cpu_n` is low while `en_pri_n` is low. The loaded address is accessed in that same cycle, and the burst count restarts at zero.
- R2: While `en_pri_n` is high, a low `strobe_cpu_n` is ignored. The cycle behaves as a continuation of the current burst, at the same address or the next one according to `step_n`.
- R3: On a cycle without a load, the burst count steps by one when `step_n` is low. When `step_n` is high, the same address is accessed again.
- R4: With `order_lin` = 1, the low two address bits are (loaded low bits + count) mod 4. The upper bits keep their loaded value, so the fifth word of a burst returns to the first.
- R5: With `order_lin` = 0, the low two address bits are the loaded low bits XOR the count, and the upper bits stay unchanged.
- R6: While `lane_gate_n` is low, a low `lane_wr_n[0]` writes `wdata[8:0]` and a low `lane_wr_n[1]` writes `wdata[17:9]`. While `lane_gate_n` is high, the lane enables have no effect, and the cycle is a read.
- R7: A low `wr_all_n` writes both lanes, whatever the state of the lane enables and the gate.
- R8: A read accessed at clock edge k drives `rdata` with `rdata_oe` = 1 after edge k+1, for one clock. A burst therefore delivers one word per clock. Write cycles and idle cycles leave `rdata_oe` at 0 in their output slot.
- R9: A read of an address that was written in the previous cycle returns the newly written data.
- R10: A load with any chip enable inactive deselects the device. The enables are active when `en_pri_n` = 0, `en_hi` = 1 and `en_lo_n` = 0. A deselected device performs no reads or writes until the next selecting load, and its output slot after the load edge is undriven.
- R11: With `out_en_n` high, `rdata_oe` is 0 and `rdata` is zero at once, without waiting for a clock edge.
- R12: After reset, the device is deselected and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| order_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address, loaded by a strobe |
| wdata | input | 18 | Write data; lane 0 is bits 8:0, lane 1 is bits 17:9 |
| en_pri_n | input | 1 | Primary chip enable, active low; also gates `strobe_cpu_n` |
| en_hi | input | 1 | Expansion chip enable, active high |
| en_lo_n | input | 1 | Expansion chip enable, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| lane_gate_n | input | 1 | Gate for the per-lane write enables, active low |
| lane_wr_n | input | 2 | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 18 | Read data; zero when not driven |
| rdata_oe | output | 1 | Pad drive flag for `rdata` |

## Verification
Every access is decided at the edge where its inputs are sampled, but its read data is due only after the following edge. The bench drives each cycle's inputs at a falling edge. It checks the outcome of a cycle two falling edges later, through a two-deep queue of expected values, so every output slot is compared. In each slot the bench checks the drive flag, whether a read, a write or nothing was expected, and it also checks the data word after a read. This places pass-through reads, the slot after a deselecting load, and the wrap-around of a burst in exactly the cycle where each is due. The output-enable probe is asynchronous, so it is checked a fraction of a cycle after `out_en_n` toggles, inside a slot where data is due.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int BURST_W = 2;

  typedef logic [BURST_W-1:0] burst_cnt_t;

  // Low address bits of the word at burst position cnt.
  function automatic burst_cnt_t burst_low(input burst_cnt_t start,
                                           input burst_cnt_t cnt,
                                           input logic lin);
    burst_cnt_t r;
    if (lin) r = start + cnt;
    else     r = start ^ cnt;
    return r;
  endfunction

endpackage

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
  import burst_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          order_lin,
  input  logic [AW-1:0] addr,
  input  logic          en_pri_n,
  input  logic          en_hi,
  input  logic          en_lo_n,
  input  logic          strobe_cpu_n,
  input  logic          strobe_ctl_n,
  input  logic          step_n,
  output logic [AW-1:0] acc_addr,
  output logic          acc_act,
  output logic          ld,
  output logic          sel_req,
  output burst_cnt_t    cnt,
  output logic [AW-1:0] base
);

  logic [AW-1:0] base_q, base_use;
  burst_cnt_t    cnt_q, cnt_use;
  logic          sel_q;

  always_comb begin
    ld       = !strobe_ctl_n || (!strobe_cpu_n && !en_pri_n);
    sel_req  = !en_pri_n && en_hi && !en_lo_n;
    base_use = ld ? addr : base_q;
    if (ld)          cnt_use = '0;
    else if (!step_n) cnt_use = cnt_q + burst_cnt_t'(1);
    else             cnt_use = cnt_q;
    acc_act  = ld ? sel_req : sel_q;
    acc_addr = {base_use[AW-1:BURST_W], burst_low(base_use[BURST_W-1:0], cnt_use, order_lin)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_use;
      cnt_q  <= cnt_use;
      sel_q  <= acc_act;
    end
  end

  assign cnt  = cnt_q;
  assign base = base_q;

endmodule

// File: rtl/burst_sram_wdec.sv
module burst_sram_wdec #(
  parameter int LANES = 2
) (
  input  logic             wr_all_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lane_we
);

  always_comb begin
    lane_we = {LANES{!wr_all_n}} | ({LANES{!lane_gate_n}} & ~lane_wr_n);
  end

endmodule

// File: rtl/burst_sram_mem.sv
module burst_sram_mem #(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANE_W * LANES
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[l]) cells[waddr] <= wdata[l*LANE_W +: LANE_W];
      if (re)    rd_q <= cells[raddr];
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_sram_rpipe.sv
module burst_sram_rpipe #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr_in,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr,
  output logic          q_en
);

  logic          go_q, en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      addr_q <= '0;
      en_q   <= 1'b0;
    end else begin
      go_q   <= rd_req;
      addr_q <= rd_addr_in;
      en_q   <= go_q;
    end
  end

  assign rd_go   = go_q;
  assign rd_addr = addr_q;
  assign q_en    = en_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             order_lin,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             en_pri_n,
  input  logic             en_hi,
  input  logic             en_lo_n,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             out_en_n,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);

  logic [AW-1:0]    acc_addr, base_w, rd_addr;
  logic             acc_act, ld_w, sel_w;
  burst_cnt_t       cnt_w;
  logic [LANES-1:0] lane_we;
  logic             wr_any, rd_req, rd_go, q_en;
  logic [DW-1:0]    mem_q;

  burst_sram_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .order_lin(order_lin), .addr(addr),
    .en_pri_n(en_pri_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
    .acc_addr(acc_addr), .acc_act(acc_act), .ld(ld_w), .sel_req(sel_w),
    .cnt(cnt_w), .base(base_w)
  );

  burst_sram_wdec #(.LANES(LANES)) u_wdec (
    .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
    .lane_we(lane_we)
  );

  always_comb begin
    wr_any = acc_act && (|lane_we);
    rd_req = acc_act && !(|lane_we);
  end

  burst_sram_rpipe #(.AW(AW)) u_rpipe (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr_in(acc_addr),
    .rd_go(rd_go), .rd_addr(rd_addr), .q_en(q_en)
  );

  burst_sram_mem #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk(clk), .we(lane_we & {LANES{acc_act}}), .waddr(acc_addr), .wdata(wdata),
    .re(rd_go), .raddr(rd_addr), .rdata(mem_q)
  );

  always_comb begin
    rdata_oe = q_en && !out_en_n;
    rdata    = rdata_oe ? mem_q : '0;
  end

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld,
  input logic          sel_req,
  input logic          act,
  input logic          wr_any,
  input logic [1:0]    cnt,
  input logic [AW-1:0] base,
  input logic          strobe_ctl_n,
  input logic          en_pri_n,
  input logic          step_n,
  input logic          q_en
);

  // R1: a load restarts the burst count
  p_fresh_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == 2'd0));

  // R2: processor strobe is ignored while the primary enable is high
  p_cpu_strobe_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ctl_n && en_pri_n) |=> $stable(base));

  // R3: the count holds without advance and steps by one with it
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && step_n) |=> $stable(cnt));
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !step_n) |=> (cnt == $past(cnt) + 2'd1));

  // R8: a read access drives the output two edges later, a write does not
  p_read_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !wr_any) |-> ##2 q_en);
  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act && wr_any) |-> ##2 !q_en);

  // R10: a deselecting load leaves its output slot undriven
  p_deselect_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !sel_req) |-> ##2 !q_en);

endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld_w), .sel_req(sel_w), .act(acc_act),
  .wr_any(wr_any), .cnt(cnt_w), .base(base_w), .strobe_ctl_n(strobe_ctl_n),
  .en_pri_n(en_pri_n), .step_n(step_n), .q_en(q_en)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int DW    = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          order_lin = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          en_pri_n = 1'b1, en_hi = 1'b0, en_lo_n = 1'b1;
  logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, step_n = 1'b1;
  logic          wr_all_n = 1'b1, lane_gate_n = 1'b1;
  logic [1:0]    lane_wr_n = 2'b11;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  always #4 clk = ~clk;

  burst_sram #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .order_lin(order_lin), .addr(addr), .wdata(wdata),
    .en_pri_n(en_pri_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
    .out_en_n(out_en_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt  = '0;
  logic          m_sel  = 1'b0;

  // next-cycle pin values
  logic          b_p_n, b_c_n, b_v_n, b_e_n, b_e2, b_e2_n, b_g_n, b_bg_n;
  logic [1:0]    b_l_n;
  logic [AW-1:0] b_a;
  logic [DW-1:0] b_d;
  bit            probe_oe = 0;

  // two-deep queue of expected output slots
  logic          p1_v = 0, p2_v = 0;
  logic [DW-1:0] p1_d = '0, p2_d = '0;
  string         p1_t = "R12", p2_t = "R12";

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 2749 + s * 613 + 32'h15A3) & 32'h3FFFF);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act_v,
                       input logic [DW-1:0] exp_v, input string what);
    vectors++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
    end
  endtask

  task automatic pins_idle();
    b_p_n = 1; b_c_n = 1; b_v_n = 1;
    b_e_n = 0; b_e2 = 1; b_e2_n = 0;
    b_g_n = 1; b_bg_n = 1; b_l_n = 2'b11;
    b_a = '0; b_d = '0;
  endtask

  task automatic go(input string tag);
    logic          ld, wl, wh;
    logic [AW-1:0] ea;
    logic [1:0]    lo;
    @(negedge clk);
    check(p2_t, DW'(rdata_oe), DW'(p2_v), "drive flag");
    if (p2_v) check(p2_t, rdata, p2_d, "read data");
    if (probe_oe && p2_v) begin
      out_en_n = 1'b1;
      #1;
      check("R11", DW'(rdata_oe), DW'(0), "flag with output enable off");
      check("R11", rdata, '0, "data with output enable off");
      out_en_n = 1'b0;
      #1;
      check("R11", rdata, p2_d, "data after output enable restored");
    end
    p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
    // reference cycle
    ld = !b_c_n || (!b_p_n && !b_e_n);
    if (ld) begin
      m_base = b_a; m_cnt = 2'd0; m_sel = !b_e_n && b_e2 && !b_e2_n;
    end else if (!b_v_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    lo = order_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    ea = {m_base[AW-1:2], lo};
    wl = !b_g_n || (!b_bg_n && !b_l_n[0]);
    wh = !b_g_n || (!b_bg_n && !b_l_n[1]);
    p1_t = tag;
    p1_v = 0;
    if (m_sel && (wl || wh)) begin
      if (wl) ref_mem[ea][8:0]  = b_d[8:0];
      if (wh) ref_mem[ea][17:9] = b_d[17:9];
    end else if (m_sel) begin
      p1_v = 1; p1_d = ref_mem[ea];
    end
    strobe_cpu_n = b_p_n; strobe_ctl_n = b_c_n; step_n = b_v_n;
    en_pri_n = b_e_n; en_hi = b_e2; en_lo_n = b_e2_n;
    wr_all_n = b_g_n; lane_gate_n = b_bg_n; lane_wr_n = b_l_n;
    addr = b_a; wdata = b_d;
  endtask

  task automatic desel(input string tag);
    pins_idle(); b_c_n = 0; b_e2 = 0; go(tag);
  endtask

  task automatic load_rd(input int a, input bit use_cpu, input string tag);
    pins_idle(); b_a = AW'(a);
    if (use_cpu) b_p_n = 0; else b_c_n = 0;
    go(tag);
  endtask

  task automatic adv_rd(input string tag);
    pins_idle(); b_v_n = 0; go(tag);
  endtask

  task automatic load_wr(input int a, input logic [DW-1:0] d, input logic g_n,
                         input logic bg_n, input logic [1:0] l_n, input string tag);
    pins_idle(); b_c_n = 0; b_a = AW'(a); b_d = d;
    b_g_n = g_n; b_bg_n = bg_n; b_l_n = l_n;
    go(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog: run still busy after %0d cycles, expected end before", 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    pins_idle();
    repeat (3) @(posedge clk);
    #1;
    check("R12", DW'(rdata_oe), DW'(0), "flag during reset");
    rst_n = 1'b1;
    // R12: no access happens before a load, so the first slots stay undriven
    pins_idle(); go("R12");
    pins_idle(); go("R12");
    // R7: fill with all-lane writes (lane controls set to non-writing)
    for (int a = 0; a < DEPTH; a++) load_wr(a, pat(a, 0), 1'b0, 1'b1, 2'b11, "R7");
    // R4 / R5 / R1 / R3: bursts from every start, both orders, both strobes
    for (int m = 0; m < 2; m++) begin
      order_lin = (m == 0);
      for (int s = 0; s < 4; s++) begin
        for (int h = 0; h < 2; h++) begin
          load_rd(h * 36 + s, (s % 2) == 1, "R1");
          for (int k = 0; k < 4; k++) adv_rd(m == 0 ? "R4" : "R5");
          pins_idle(); go("R3");
        end
      end
    end
    order_lin = 1'b1;
    // R2: processor strobe with primary enable high does not reload
    load_rd(21, 1'b1, "R1");
    pins_idle(); b_p_n = 0; b_e_n = 1; b_a = AW'(50); go("R2");
    pins_idle(); b_p_n = 0; b_e_n = 1; b_a = AW'(9); b_v_n = 0; go("R2");
    // R6: every lane-enable combination under the gate, each read back at once
    for (int k = 0; k < 4; k++) begin
      load_wr(10, pat(10, k + 5), 1'b1, 1'b0, 2'(k), "R6");
      load_rd(10, 1'b0, "R6");
    end
    // R6: gate high turns the lane enables off; the cycle reads
    load_wr(11, pat(11, 9), 1'b1, 1'b1, 2'b00, "R6");
    load_rd(11, 1'b0, "R6");
    // R7: all-lane write overrides disabled lanes and a closed gate
    load_wr(12, pat(12, 7), 1'b0, 1'b1, 2'b11, "R7");
    load_rd(12, 1'b0, "R7");
    load_wr(13, pat(13, 8), 1'b0, 1'b0, 2'b10, "R7");
    load_rd(13, 1'b0, "R7");
    // R9: burst write then burst read of the same words, and read after write
    load_wr(40, pat(40, 3), 1'b0, 1'b1, 2'b11, "R9");
    for (int k = 0; k < 3; k++) begin
      pins_idle(); b_v_n = 0; b_g_n = 0; b_d = pat(40 + k + 1, 3); go("R9");
    end
    load_rd(40, 1'b0, "R9");
    for (int k = 0; k < 3; k++) adv_rd("R9");
    load_wr(41, pat(41, 11), 1'b0, 1'b1, 2'b11, "R9");
    load_rd(41, 1'b0, "R9");
    // R10: each enable alone deselects; writes while deselected are dropped
    for (int w = 0; w < 3; w++) begin
      load_rd(30, 1'b0, "R8");
      pins_idle(); b_c_n = 0; b_a = AW'(30);
      b_e_n = (w == 0); b_e2 = (w != 1); b_e2_n = (w == 2);
      go("R10");
      pins_idle(); b_v_n = 0; b_g_n = 0; b_d = pat(30, 20 + w); go("R10");
      pins_idle(); go("R10");
      load_rd(30, 1'b0, "R10");
      adv_rd("R10");
    end
    // R11: asynchronous output enable during a read slot
    probe_oe = 1;
    load_rd(5, 1'b0, "R8");
    desel("R8");
    desel("R8");
    probe_oe = 0;
    desel("R8");
    desel("R8");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule